// File: doc/BRIEF.md
# Multiplexed LCD Frame Sequencer

This block generates the digital timing for a multiplexed segment LCD panel. It runs on a clock that comes from a watch-timer prescaler. It counts only while the watch-timer enable is high. It divides that clock down to one of four frame rates and splits every frame into as many common phases as the selected duty needs: four, three, two or one. For each phase it fetches one row of segment levels from display memory, addressed by the active common index. It presents that row on the segment outputs together with the common index, the active duty code and a polarity flag. The flag flips every frame, so the analog driver further down can keep the panel free of DC.

An 8-bit control word sets the behaviour:

| Bits | Meaning |
|---|---|
| 5 | display on |
| 3:2 | duty |
| 1:0 | frame-rate select |
| 7, 6, 4 | analog and power controls (not used here) |

Duty and frame-rate changes are held back until the next frame boundary. The display-on bit acts at once.

Three pins above the 24 dedicated segment pins are shared. Pin 24 serves as common 3, pin 25 as common 2 and pin 26 as common 1. When the duty drops far enough that a common is unused, its pin reverts to an ordinary segment. Common 0 has its own pin.

The sequencer is a small state machine with three states:
- ST_IDLE: after reset, nothing loaded.
- ST_RUN: counting.
- ST_PAUSE: watch timer stopped, all state frozen.

Its transitions are:
- IDLE to RUN on the first enabled cycle, which loads a frame start.
- RUN to PAUSE when the enable falls.
- PAUSE to RUN when the enable returns. Counting resumes where it stopped.

Top module: `lcd_frame_seq`

## Requirements
- R1: Out of reset the common index is 0, the polarity flag is 0, the active duty is code 00 (all three shared pins act as commons, shared mask 3'b111), and the segment outputs are 0. The block stays idle with these values until the watch-timer enable is first seen high.
- R2: A frame lasts 2^(LOG_PRE+5+s) enabled clock cycles, where s is the latched frame-rate select (ctrl bits 1:0). The polarity flag toggles at each frame boundary.
- R3: The latched duty code d (ctrl bits 3:2) gives N = 4 - d commons. During frame position p (0 to F-1), the common index is floor(p*N/F), so it always stays below N.
- R4: Shared mask bit 0 (pin 24) is set only for duty 00. Bit 1 (pin 25) is set for duty 00 and 01. Bit 2 (pin 26) is set for every duty except 11. A shared pin acting as a common drives segment level 0.
- R5: While ctrl bit 5 is 0, every segment output is 0 in the same cycle, whatever the display memory holds.
- R6: While the watch-timer enable is low, the counter, common index, polarity flag and segment data hold their values.
- R7: A change to ctrl bits 3:2 or 1:0 takes effect only at the next frame boundary.
- R8: The memory row addressed by the new common index is captured in the first cycle of each phase. Later changes to that row during the phase do not reach the outputs.
- R9: Ctrl bits 7, 6 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled watch-timer clock |
| rst_n | input | 1 | Active-low reset |
| wt_en | input | 1 | Watch-timer enable; the sequencer advances only while high |
| ctrl_i | input | 8 | Control word (bit 5 display on, bits 3:2 duty, bits 1:0 frame rate) |
| mem_com_o | output | 2 | Common index addressing the display memory |
| mem_row_i | input | NSEG | Segment row returned for mem_com_o |
| com_idx_o | output | 2 | Active common index |
| ac_o | output | 1 | Frame polarity flag |
| duty_o | output | 2 | Duty code in effect for the current frame |
| seg_o | output | NSEG | Segment levels, pins 0 to NSEG-1 |
| shared_com_o | output | 3 | Shared pins 24..26 currently acting as commons |

## Verification
The bench runs all four duty codes at the fastest rate. The 1/3 case is the one that tells a floor-scaled phase split apart from an even-length or per-phase counter. It also runs all four frame rates, so that an off-by-one in the frame length or a wrong polarity toggle point shows up as an early or late return to common 0. Control changes are made mid-frame to separate a deferred load from an immediate one. Memory rows are rewritten mid-phase to separate sampling at the start of a phase from a continuous read. Pauses of the enable, blanking, and changes to the unused control bits are each run against a cycle-level model, to show they freeze or leave alone exactly what they should.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } seq_state_t;

    localparam int NCOM_MAX = 4;
    localparam int NSHARED  = NCOM_MAX - 1;
    localparam int BASE_DIV_LOG = 5;

    // number of common phases for a duty code
    function automatic logic [2:0] ncom_of(input logic [1:0] duty);
        return 3'd4 - {1'b0, duty};
    endfunction

    // shared pin j (pin 24+j) carries common 3-j while that common is in use
    function automatic logic [NSHARED-1:0] shared_of(input logic [1:0] duty);
        return {duty != 2'd3, duty <= 2'd1, duty == 2'd0};
    endfunction

endpackage

// File: rtl/lcd_phase_calc.sv
module lcd_phase_calc #(
    parameter int CW       = 15,
    parameter int LOG_BASE = 12
) (
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    fsel,
    input  logic [1:0]    duty,
    output logic          frame_end,
    output logic [CW-1:0] cnt_nxt,
    output logic [1:0]    phase_nxt
);
    import lcd_seq_pkg::*;

    localparam int PW = CW + 3;

    logic [CW:0]   flen;
    logic [CW-1:0] flast;
    logic [PW-1:0] prod;
    int            sh;

    always_comb begin
        sh        = LOG_BASE + int'(fsel);
        flen      = (CW+1)'(1) << sh;
        flast     = CW'(flen - (CW+1)'(1));
        frame_end = (cnt == flast);
        cnt_nxt   = cnt + CW'(1);
        prod      = PW'(cnt_nxt) * PW'(ncom_of(duty));
        phase_nxt = 2'(prod >> sh);
    end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive #(
    parameter int NDED = 24,
    parameter int NSH  = 3
) (
    input  logic [NDED+NSH-1:0] seg_row,
    input  logic [1:0]          duty,
    input  logic                disp_en,
    output logic [NDED+NSH-1:0] seg_o,
    output logic [NSH-1:0]      shared_com
);
    import lcd_seq_pkg::*;

    always_comb begin
        shared_com = shared_of(duty);
        seg_o      = '0;
        if (disp_en) begin
            seg_o = seg_row & ~{shared_com, {NDED{1'b0}}};
        end
    end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
    parameter int LOG_PRE = 7,
    parameter int NDED    = 24,
    localparam int NSH    = lcd_seq_pkg::NSHARED,
    localparam int NSEG   = NDED + NSH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wt_en,
    input  logic [7:0]      ctrl_i,
    output logic [1:0]      mem_com_o,
    input  logic [NSEG-1:0] mem_row_i,
    output logic [1:0]      com_idx_o,
    output logic            ac_o,
    output logic [1:0]      duty_o,
    output logic [NSEG-1:0] seg_o,
    output logic [NSH-1:0]  shared_com_o
);
    import lcd_seq_pkg::*;

    localparam int LOG_BASE = LOG_PRE + BASE_DIV_LOG;
    localparam int CW       = LOG_BASE + 3;

    seq_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_nxt;
    logic [1:0]      phase_q, phase_nxt;
    logic [1:0]      duty_q, fsel_q;
    logic            ac_q;
    logic [NSEG-1:0] row_q;
    logic            frame_end, load_frame, advance, running;

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl_i[7:6], ctrl_i[4]};

    lcd_phase_calc #(.CW(CW), .LOG_BASE(LOG_BASE)) u_calc (
        .cnt       (cnt_q),
        .fsel      (fsel_q),
        .duty      (duty_q),
        .frame_end (frame_end),
        .cnt_nxt   (cnt_nxt),
        .phase_nxt (phase_nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-state controls
    always_comb begin
        state_d = state_q;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wt_en) state_d = ST_RUN;
            end
            ST_RUN: begin
                running = 1'b1;
                if (!wt_en) state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                running = 1'b1;
                if (wt_en) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
        load_frame = wt_en && (!running || frame_end);
        advance    = wt_en && running && !frame_end;
        mem_com_o  = advance ? phase_nxt : 2'd0;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= '0;
            duty_q  <= '0;
            fsel_q  <= '0;
            ac_q    <= 1'b0;
            row_q   <= '0;
        end else if (load_frame) begin
            cnt_q   <= '0;
            phase_q <= '0;
            duty_q  <= ctrl_i[3:2];
            fsel_q  <= ctrl_i[1:0];
            row_q   <= mem_row_i;
            if (running) ac_q <= ~ac_q;
        end else if (advance) begin
            cnt_q   <= cnt_nxt;
            phase_q <= phase_nxt;
            if (phase_nxt != phase_q) row_q <= mem_row_i;
        end
    end

    lcd_seg_drive #(.NDED(NDED), .NSH(NSH)) u_drive (
        .seg_row    (row_q),
        .duty       (duty_q),
        .disp_en    (ctrl_i[5]),
        .seg_o      (seg_o),
        .shared_com (shared_com_o)
    );

    assign com_idx_o = phase_q;
    assign ac_o      = ac_q;
    assign duty_o    = duty_q;

endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk #(
    parameter int NDED = 24,
    parameter int NSH  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wt_en,
    input logic [7:0]          ctrl_i,
    input logic [1:0]          com_idx_o,
    input logic                ac_o,
    input logic [1:0]          duty_o,
    input logic [NDED+NSH-1:0] seg_o,
    input logic [NSH-1:0]      shared_com_o
);

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !wt_en |=> ($stable(com_idx_o) && $stable(ac_o) && $stable(duty_o))); // R6

    AST_BLANK_SEGS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[5] |-> (seg_o == '0)); // R5

    AST_SHARED_COM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_o[NDED+NSH-1:NDED] & shared_com_o) == '0)); // R4

    AST_COM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, com_idx_o} < (3'd4 - {1'b0, duty_o}))); // R3

    AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_o) |-> (com_idx_o == 2'd0)); // R7

    AST_AC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_o) |-> (com_idx_o == 2'd0)); // R2

endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(.NDED(NDED), .NSH(NSH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wt_en        (wt_en),
    .ctrl_i       (ctrl_i),
    .com_idx_o    (com_idx_o),
    .ac_o         (ac_o),
    .duty_o       (duty_o),
    .seg_o        (seg_o),
    .shared_com_o (shared_com_o)
);

// File: tb/lcd_frame_seq_tb.sv
module lcd_frame_seq_tb;

    localparam int NSEG = 27;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wt_en = 1'b0;
    logic [7:0]      ctrl = 8'h00;
    logic [1:0]      mem_com;
    logic [NSEG-1:0] mem_row;
    logic [1:0]      com_idx;
    logic            ac;
    logic [1:0]      duty;
    logic [NSEG-1:0] seg;
    logic [2:0]      shared;
    logic [NSEG-1:0] row [4];

    int errors = 0;
    int checks = 0;

    // bench model state
    bit              m_run = 0;
    int              m_cnt = 0;
    int              m_ph  = 0;
    logic [1:0]      m_duty = 2'd0;
    logic [1:0]      m_fsel = 2'd0;
    logic            m_ac = 1'b0;
    logic [NSEG-1:0] m_seg = '0;

    always #4 clk = ~clk;

    assign mem_row = row[mem_com];

    lcd_frame_seq #(.LOG_PRE(0)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wt_en        (wt_en),
        .ctrl_i       (ctrl),
        .mem_com_o    (mem_com),
        .mem_row_i    (mem_row),
        .com_idx_o    (com_idx),
        .ac_o         (ac),
        .duty_o       (duty),
        .seg_o        (seg),
        .shared_com_o (shared)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int flen(input logic [1:0] fs);
        return 32 << fs;
    endfunction

    function automatic logic [2:0] exp_shared(input logic [1:0] d);
        return {d != 2'd3, d <= 2'd1, d == 2'd0};
    endfunction

    task automatic compare(input string tag);
        logic [2:0]      sh;
        logic [NSEG-1:0] es;
        sh = exp_shared(m_duty);
        es = ctrl[5] ? (m_seg & ~{sh, 24'b0}) : '0;
        check(tag, "com_idx", 32'(com_idx), 32'(m_ph));
        check(tag, "ac", 32'(ac), 32'(m_ac));
        check(tag, "duty", 32'(duty), 32'(m_duty));
        check(tag, "shared", 32'(shared), 32'(sh));
        check(tag, "seg", 32'(seg), 32'(es));
    endtask

    task automatic tick(input string tag);
        int np;
        @(posedge clk);
        if (wt_en) begin
            if (!m_run || m_cnt == flen(m_fsel) - 1) begin
                if (m_run) m_ac = ~m_ac;
                m_run  = 1;
                m_cnt  = 0;
                m_ph   = 0;
                m_duty = ctrl[3:2];
                m_fsel = ctrl[1:0];
                m_seg  = row[0];
            end else begin
                m_cnt++;
                np = (m_cnt * (4 - int'(m_duty))) / flen(m_fsel);
                if (np != m_ph) begin
                    m_ph  = np;
                    m_seg = row[np];
                end
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic t_reset();
        row[0] = 27'h2A5_5A3C; row[1] = 27'h153_C3A5;
        row[2] = 27'h6F0_0FF1; row[3] = 27'h70F_F00E;
        rst_n = 1'b0; wt_en = 1'b0; ctrl = 8'h00;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        ctrl = 8'h20;
        for (int i = 0; i < 5; i++) tick("R1");
    endtask

    task automatic t_quarter();
        wt_en = 1'b1; ctrl = 8'h20;
        for (int i = 0; i < 80; i++) tick("R3");
    endtask

    task automatic t_rates();
        for (int f = 1; f < 4; f++) begin
            ctrl = 8'h20 | 8'(f);
            for (int i = 0; i < 2 * (32 << f) + 40; i++) tick("R2");
        end
        ctrl = 8'h20;
        for (int i = 0; i < 300; i++) tick("R2");
    endtask

    task automatic t_duties();
        for (int d = 1; d < 4; d++) begin
            ctrl = 8'h20 | 8'(d << 2);
            for (int i = 0; i < 75; i++) tick("R4");
        end
    endtask

    task automatic t_config_defer();
        ctrl = 8'h24;
        for (int i = 0; i < 45; i++) tick("R7");
        for (int i = 0; i < 11; i++) tick("R7");
        ctrl = 8'h29;
        for (int i = 0; i < 150; i++) tick("R7");
        ctrl = 8'h20;
        for (int i = 0; i < 100; i++) tick("R7");
    endtask

    task automatic t_pause();
        for (int i = 0; i < 13; i++) tick("R6");
        wt_en = 1'b0;
        for (int i = 0; i < 12; i++) tick("R6");
        wt_en = 1'b1;
        for (int i = 0; i < 30; i++) tick("R6");
    endtask

    task automatic t_blank();
        ctrl = 8'h00;
        for (int i = 0; i < 40; i++) tick("R5");
        ctrl = 8'h20;
        for (int i = 0; i < 10; i++) tick("R5");
    endtask

    task automatic t_sample();
        for (int i = 0; i < 64; i++) begin
            row[m_ph] = row[m_ph] ^ 27'(32'h0123_4567 * (i + 1));
            tick("R8");
        end
    endtask

    task automatic t_ignored();
        ctrl = 8'hF4;
        for (int i = 0; i < 70; i++) tick("R9");
        ctrl = 8'h14;
        for (int i = 0; i < 20; i++) tick("R9");
        ctrl = 8'h20;
    endtask

    initial begin
        t_reset();
        t_quarter();
        t_rates();
        t_duties();
        t_config_defer();
        t_pause();
        t_blank();
        t_sample();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule